// File: doc/BRIEF.md
# Write-Through Secondary Cache with Store-Width Control

This block is a direct-mapped, physically indexed, write-through secondary cache that sits between a processor request port and main memory. Lines are 32 bytes. A read miss fetches the whole line from memory in one burst. Every store is forwarded to memory as a single word write with byte lanes. A store that hits also updates the cached copy, and a store that misses leaves the arrays alone.

The cache has no control register. Software steers it with plain stores into a reserved physical window that starts at `WIN_BASE` and is `CACHE_BYTES` long. The width of the store selects the action:

- A byte store turns the cache on.
- A halfword store turns it off.
- A word store drops the one line that its window offset selects.

The stored data is ignored. Invalidating every line takes one word store per 32 bytes across the window. Reads from the window return zero. No access to the window reaches memory.

Top module: `l2wt_cache`

## Requirements
- R1: After reset the cache is disabled and every line is invalid. `cpu_ready` and `mem_req` are low.
- R2: A store with `cpu_size`=0 (byte) to any address in [`WIN_BASE`, `WIN_BASE`+`CACHE_BYTES`) enables the cache.
- R3: A store with `cpu_size`=1 (halfword) in the window disables the cache. Line contents and valid bits are kept, so lines filled earlier hit again once the cache is re-enabled.
- R4: A store with `cpu_size`=2 (word) in the window invalidates the single line whose index is address bits [log2(`CACHE_BYTES`)-1:5]. Other lines are unaffected and the store data has no effect.
- R5: Window accesses never assert `mem_req`. Window reads return zero. `cpu_ready` rises one cycle after the request is taken.
- R6: While disabled, a read performs one single-word memory read (`mem_line`=0) and leaves the arrays untouched.
- R7: An enabled read miss requests a line (`mem_line`=1) at the 32-byte aligned address. It accepts eight beats in ascending word order, fills and validates the line, and returns the requested word.
- R8: An enabled read hit makes no memory access and returns the cached word, with `cpu_ready` one cycle after acceptance.
- R9: Every store outside the window produces exactly one memory write at the word-aligned address. Byte lanes are: size 0 gives 1<<addr[1:0]; size 1 gives 0011 or 1100 by addr[1]; size 2 gives 1111. Data sits in its byte lanes.
- R10: A store hit updates the enabled lanes of the cached word. A store miss does not allocate a line.
- R11: One word store per 32 bytes across the whole window invalidates every line.
- R12: `cpu_ready` is a one-cycle pulse. Reads of any size return the whole aligned 32-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Request valid, held until `cpu_ready` |
| cpu_write | input | 1 | 1 = store, 0 = read |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_addr | input | ADDR_W | Physical byte address |
| cpu_wdata | input | 32 | Store data in byte-lane position |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read word, valid with `cpu_ready` |
| mem_req | output | 1 | Memory transaction active |
| mem_write | output | 1 | Transaction is a word write |
| mem_line | output | 1 | Read is an eight-beat line fetch |
| mem_addr | output | ADDR_W | Word or line aligned address |
| mem_be | output | 4 | Byte lanes of a write |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Write accepted |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 32 | Read beat data |

## Verification
The bench builds the cache with `CACHE_BYTES`=512 (16 lines) and the default window base. It keeps normal traffic inside a 4 KB memory model, which is eight times the cache. Random addresses therefore alias heavily on every index, so tag mismatches, refills over valid lines and store misses next to valid lines all occur often. The small line count also makes a complete window flush only sixteen stores long.

// File: rtl/l2wt_pkg.sv
package l2wt_pkg;

    localparam int unsigned LINE_BYTES = 32;
    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned LINE_WORDS = LINE_BYTES / WORD_BYTES;
    localparam int unsigned OFF_W      = $clog2(LINE_BYTES);
    localparam int unsigned WSEL_W     = $clog2(LINE_WORDS);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_ENABLE,
        CMD_DISABLE,
        CMD_INVAL
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STORE,
        ST_SINGLE,
        ST_FILL,
        ST_RESP
    } state_e;

    typedef struct packed {
        logic [WORD_BYTES-1:0] lanes;
        logic [31:0]           data;
    } store_t;

    function automatic logic [WORD_BYTES-1:0] lane_mask(input size_e sz, input logic [1:0] lo);
        case (sz)
            SZ_BYTE: return 4'b0001 << lo;
            SZ_HALF: return lo[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/l2wt_win_decode.sv
module l2wt_win_decode import l2wt_pkg::*; #(
    parameter int unsigned       ADDR_W      = 32,
    parameter int unsigned       CACHE_BYTES = 1024,
    parameter logic [ADDR_W-1:0] WIN_BASE    = 32'h8000_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  size_e             size,
    output logic              in_win,
    output cmd_e              cmd
);

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = addr - WIN_BASE;
        in_win = (addr >= WIN_BASE) && (offset < ADDR_W'(CACHE_BYTES));
        cmd    = CMD_NONE;
        if (in_win && write) begin
            case (size)
                SZ_BYTE: cmd = CMD_ENABLE;
                SZ_HALF: cmd = CMD_DISABLE;
                SZ_WORD: cmd = CMD_INVAL;
                default: cmd = CMD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/l2wt_tag_store.sv
module l2wt_tag_store #(
    parameter int unsigned LINES = 32,
    parameter int unsigned IDX_W = 5,
    parameter int unsigned TAG_W = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] look_idx,
    output logic             look_valid,
    output logic [TAG_W-1:0] look_tag,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_idx
);

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else begin
            if (fill_en) valid_q[fill_idx] <= 1'b1;
            if (inv_en)  valid_q[inv_idx]  <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) tag_q[fill_idx] <= fill_tag;
    end

    assign look_valid = valid_q[look_idx];
    assign look_tag   = tag_q[look_idx];

    // R4
    inval_clears_chk: assert property (@(posedge clk) disable iff (rst)
        inv_en |=> !valid_q[$past(inv_idx)]);

    // R7
    fill_sets_chk: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> valid_q[$past(fill_idx)]);

endmodule

// File: rtl/l2wt_data_store.sv
module l2wt_data_store import l2wt_pkg::*; #(
    parameter int unsigned LINES = 32,
    parameter int unsigned IDX_W = 5
) (
    input  logic                  clk,
    input  logic [IDX_W-1:0]      rd_idx,
    input  logic [WSEL_W-1:0]     rd_word,
    output logic [31:0]           rd_data,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [WSEL_W-1:0]     wr_word,
    input  logic [WORD_BYTES-1:0] wr_lanes,
    input  logic [31:0]           wr_data
);

    localparam int unsigned DEPTH = LINES * LINE_WORDS;
    localparam int unsigned AW    = IDX_W + WSEL_W;

    logic [AW-1:0] rd_a;
    logic [AW-1:0] wr_a;

    assign rd_a = {rd_idx, rd_word};
    assign wr_a = {wr_idx, wr_word};

    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
        logic [7:0] bank_q [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[b]) bank_q[wr_a] <= wr_data[8*b +: 8];
        end

        assign rd_data[8*b +: 8] = bank_q[rd_a];
    end

endmodule

// File: rtl/l2wt_cache.sv
module l2wt_cache import l2wt_pkg::*; #(
    parameter int unsigned       ADDR_W      = 32,
    parameter int unsigned       CACHE_BYTES = 1024,
    parameter logic [ADDR_W-1:0] WIN_BASE    = 32'h8000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [1:0]        cpu_size,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic              cpu_ready,
    output logic [31:0]       cpu_rdata,
    output logic              mem_req,
    output logic              mem_write,
    output logic              mem_line,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata
);

    localparam int unsigned LINES = CACHE_BYTES / LINE_BYTES;
    localparam int unsigned IDX_W = $clog2(LINES);
    localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int unsigned WA_W  = ADDR_W - 2;

    state_e              state_q;
    logic                en_q;
    logic [WSEL_W-1:0]   beat_q;
    logic [31:0]         rdata_q;
    logic [WA_W-1:0]     waddr_q;
    store_t              st_q;

    size_e               req_sz;
    logic [IDX_W-1:0]    cur_idx;
    logic [TAG_W-1:0]    cur_tag;
    logic [WSEL_W-1:0]   cur_word;
    logic [IDX_W-1:0]    q_idx;
    logic [TAG_W-1:0]    q_tag;
    logic [WSEL_W-1:0]   q_word;
    logic                in_win;
    cmd_e                cmd;
    logic                look_valid;
    logic [TAG_W-1:0]    look_tag;
    logic                hit;
    logic                accept;
    logic                last_beat;
    logic [31:0]         arr_rdata;
    logic                arr_we;
    logic [IDX_W-1:0]    arr_widx;
    logic [WSEL_W-1:0]   arr_wword;
    logic [3:0]          arr_lanes;
    logic [31:0]         arr_wdata;

    assign req_sz    = size_e'(cpu_size);
    assign cur_idx   = cpu_addr[OFF_W +: IDX_W];
    assign cur_tag   = cpu_addr[ADDR_W-1 -: TAG_W];
    assign cur_word  = cpu_addr[2 +: WSEL_W];
    assign q_idx     = waddr_q[WSEL_W +: IDX_W];
    assign q_tag     = waddr_q[WA_W-1 -: TAG_W];
    assign q_word    = waddr_q[WSEL_W-1:0];
    assign hit       = en_q && look_valid && (look_tag == cur_tag);
    assign accept    = (state_q == ST_IDLE) && cpu_valid;
    assign last_beat = (beat_q == WSEL_W'(LINE_WORDS - 1));

    l2wt_win_decode #(.ADDR_W(ADDR_W), .CACHE_BYTES(CACHE_BYTES), .WIN_BASE(WIN_BASE)) u_dec (
        .addr(cpu_addr), .write(cpu_write), .size(req_sz), .in_win(in_win), .cmd(cmd)
    );

    l2wt_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst(rst),
        .look_idx(cur_idx), .look_valid(look_valid), .look_tag(look_tag),
        .fill_en((state_q == ST_FILL) && mem_rvalid && last_beat),
        .fill_idx(q_idx), .fill_tag(q_tag),
        .inv_en(accept && (cmd == CMD_INVAL)), .inv_idx(cur_idx)
    );

    always_comb begin
        if (state_q == ST_FILL) begin
            arr_we    = mem_rvalid;
            arr_widx  = q_idx;
            arr_wword = beat_q;
            arr_lanes = 4'hF;
            arr_wdata = mem_rdata;
        end else begin
            arr_we    = accept && cpu_write && !in_win && hit;
            arr_widx  = cur_idx;
            arr_wword = cur_word;
            arr_lanes = lane_mask(req_sz, cpu_addr[1:0]);
            arr_wdata = cpu_wdata;
        end
    end

    l2wt_data_store #(.LINES(LINES), .IDX_W(IDX_W)) u_data (
        .clk(clk),
        .rd_idx(cur_idx), .rd_word(cur_word), .rd_data(arr_rdata),
        .wr_en(arr_we), .wr_idx(arr_widx), .wr_word(arr_wword),
        .wr_lanes(arr_lanes), .wr_data(arr_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            en_q    <= 1'b0;
            beat_q  <= '0;
            rdata_q <= '0;
            waddr_q <= '0;
            st_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (cpu_valid) begin
                    waddr_q <= cpu_addr[ADDR_W-1:2];
                    st_q    <= '{lanes: lane_mask(req_sz, cpu_addr[1:0]), data: cpu_wdata};
                    beat_q  <= '0;
                    if (in_win) begin
                        rdata_q <= '0;
                        if (cmd == CMD_ENABLE)       en_q <= 1'b1;
                        else if (cmd == CMD_DISABLE) en_q <= 1'b0;
                        state_q <= ST_RESP;
                    end else if (cpu_write) begin
                        state_q <= ST_STORE;
                    end else if (hit) begin
                        rdata_q <= arr_rdata;
                        state_q <= ST_RESP;
                    end else if (en_q) begin
                        state_q <= ST_FILL;
                    end else begin
                        state_q <= ST_SINGLE;
                    end
                end
                ST_STORE:  if (mem_ack) state_q <= ST_RESP;
                ST_SINGLE: if (mem_rvalid) begin
                    rdata_q <= mem_rdata;
                    state_q <= ST_RESP;
                end
                ST_FILL:   if (mem_rvalid) begin
                    if (beat_q == q_word) rdata_q <= mem_rdata;
                    beat_q <= beat_q + 1'b1;
                    if (last_beat) state_q <= ST_RESP;
                end
                ST_RESP:   state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    assign cpu_ready = (state_q == ST_RESP);
    assign cpu_rdata = rdata_q;
    assign mem_req   = (state_q == ST_STORE) || (state_q == ST_SINGLE) || (state_q == ST_FILL);
    assign mem_write = (state_q == ST_STORE);
    assign mem_line  = (state_q == ST_FILL);
    assign mem_addr  = mem_line ? {waddr_q[WA_W-1:WSEL_W], {OFF_W{1'b0}}} : {waddr_q, 2'b00};
    assign mem_be    = mem_write ? st_q.lanes : 4'hF;
    assign mem_wdata = st_q.data;

    // R12
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    // R5
    win_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && in_win) |=> (cpu_ready && !mem_req));

    // R9
    store_through_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && cpu_write && !in_win) |=> (mem_req && mem_write));

    // R6
    off_single_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !cpu_write && !in_win && !en_q) |=> (mem_req && !mem_line));

    // R8
    hit_fast_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !cpu_write && !in_win && hit) |=> (cpu_ready && !mem_req));

endmodule

// File: tb/l2wt_cache_tb_top.sv
module l2wt_cache_tb_top;

    localparam int unsigned CB     = 512;
    localparam int unsigned NLINES = CB / 32;
    localparam logic [31:0] WBASE  = 32'h8000_0000;
    localparam int unsigned MEMW   = 1024;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst = 1'b1;
    logic        cpu_valid = 1'b0;
    logic        cpu_write = 1'b0;
    logic [1:0]  cpu_size = 2'd2;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_write, mem_line;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    l2wt_cache #(.ADDR_W(32), .CACHE_BYTES(CB), .WIN_BASE(WBASE)) dut_i (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_size(cpu_size),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_write(mem_write), .mem_line(mem_line),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] init_word(int unsigned i);
        return (32'(i) * 32'h0101_0107) ^ 32'hA5A5_0000;
    endfunction

    // memory model
    logic [31:0] mem_img [MEMW];
    int unsigned beat_cnt = 0;
    bit          ack_done = 1'b0;
    int unsigned rd_beats = 0;
    int unsigned wr_cnt = 0;
    bit          poke_en = 1'b0;
    int unsigned poke_idx = 0;
    logic [31:0] poke_val = '0;

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        mem_ack    <= 1'b0;
        if (rst) begin
            for (int i = 0; i < MEMW; i++) mem_img[i] <= init_word(i);
        end else if (poke_en) begin
            mem_img[poke_idx] <= poke_val;
        end
        if (!mem_req) begin
            beat_cnt <= 0;
            ack_done <= 1'b0;
        end else if (mem_write) begin
            if (!ack_done) begin
                ack_done <= 1'b1;
                mem_ack  <= 1'b1;
                wr_cnt   <= wr_cnt + 1;
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem_img[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end
        end else if (beat_cnt < (mem_line ? 8 : 1)) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem_img[(int'(mem_addr[11:2]) + beat_cnt) % MEMW];
            beat_cnt   <= beat_cnt + 1;
            rd_beats   <= rd_beats + 1;
        end
    end

    // reference state
    logic [31:0] refmem [MEMW];
    bit          r_en;
    bit          r_val [NLINES];
    int unsigned r_tag [NLINES];
    logic [31:0] r_dat [NLINES][8];
    int unsigned checks = 0;
    int unsigned errors = 0;
    int          last_beats;

    function automatic int unsigned lidx(logic [31:0] a);
        return (a >> 5) % NLINES;
    endfunction

    function automatic int unsigned ltag(logic [31:0] a);
        return a / CB;
    endfunction

    function automatic logic [3:0] tb_lanes(logic [1:0] sz, logic [1:0] lo);
        case (sz)
            2'd0:    return 4'b0001 << lo;
            2'd1:    return lo[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tg, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: act=%h exp=%h", tg, what, act, exp);
        end
    endtask

    task automatic op(input bit wr, input logic [1:0] sz, input logic [31:0] a,
                      input logic [31:0] d, output logic [31:0] rd,
                      output int beats, output int wrs, output int n, output bit pulse_ok);
        int unsigned b0, w0;
        b0 = rd_beats;
        w0 = wr_cnt;
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = wr; cpu_size = sz; cpu_addr = a; cpu_wdata = d;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!cpu_ready && n < 100);
        rd = cpu_rdata;
        cpu_valid = 1'b0;
        @(negedge clk);
        pulse_ok = !cpu_ready;
        beats = int'(rd_beats - b0);
        wrs   = int'(wr_cnt - w0);
    endtask

    task automatic run(input bit wr, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
        logic [31:0] rd, exp_rd;
        int beats, wrs, n, exp_beats;
        bit pulse_ok, win, hit, fast;
        int unsigned li, w, wi;
        logic [3:0] ln;
        string tg;
        win = (a >= WBASE) && (a < WBASE + CB);
        li = lidx(a);
        w  = (a >> 2) & 7;
        wi = (a >> 2) % MEMW;
        hit = r_en && r_val[li] && (r_tag[li] == ltag(a));
        exp_rd = '0; exp_beats = 0; fast = 1'b0;
        if (win) begin
            fast = 1'b1;
            if (!wr) tg = "R5";
            else if (sz == 2'd0) begin tg = "R2"; r_en = 1'b1; end
            else if (sz == 2'd1) begin tg = "R3"; r_en = 1'b0; end
            else begin tg = "R4"; r_val[li] = 1'b0; end
        end else if (wr) begin
            tg = hit ? "R10" : "R9";
            ln = tb_lanes(sz, a[1:0]);
            for (int b = 0; b < 4; b++) if (ln[b]) begin
                refmem[wi][8*b +: 8] = d[8*b +: 8];
                if (hit) r_dat[li][w][8*b +: 8] = d[8*b +: 8];
            end
        end else if (hit) begin
            tg = "R8"; fast = 1'b1; exp_rd = r_dat[li][w];
        end else if (r_en) begin
            tg = "R7"; exp_beats = 8; exp_rd = refmem[wi];
            for (int k = 0; k < 8; k++) r_dat[li][k] = refmem[(wi & ~32'd7) + k];
            r_val[li] = 1'b1;
            r_tag[li] = ltag(a);
        end else begin
            tg = "R6"; exp_beats = 1; exp_rd = refmem[wi];
        end
        op(wr, sz, a, d, rd, beats, wrs, n, pulse_ok);
        last_beats = beats;
        chk(n < 100, tg, "response timeout", n, 100);
        chk(beats == exp_beats, tg, "memory read beats", beats, exp_beats);
        chk(wrs == ((wr && !win) ? 1 : 0), (wr && !win) ? "R9" : tg, "memory writes", wrs, (wr && !win) ? 1 : 0);
        if (!wr) chk(rd == exp_rd, tg, "read data", rd, exp_rd);
        if (fast) chk(n == 1, tg, "response latency", n, 1);
        chk(pulse_ok, "R12", "ready pulse width", {31'd0, !pulse_ok}, 0);
        if (wr && !win) chk(mem_img[wi] == refmem[wi], "R9", "memory word after store", mem_img[wi], refmem[wi]);
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] v);
        @(negedge clk);
        poke_en = 1'b1; poke_idx = (a >> 2) % MEMW; poke_val = v;
        @(negedge clk);
        poke_en = 1'b0;
        refmem[(a >> 2) % MEMW] = v;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): act=150000 cycles exp=fewer");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned kind;
        logic [31:0] a;
        void'($urandom(32'd20240611));
        for (int i = 0; i < MEMW; i++) refmem[i] = init_word(i);
        r_en = 1'b0;
        for (int i = 0; i < NLINES; i++) begin r_val[i] = 1'b0; r_tag[i] = 0; end
        repeat (3) @(negedge clk);
        chk(cpu_ready == 1'b0, "R1", "cpu_ready in reset", {31'd0, cpu_ready}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(cpu_ready == 1'b0 && mem_req == 1'b0, "R1", "idle outputs after reset",
            {30'd0, cpu_ready, mem_req}, 0);

        run(1'b0, 2'd2, 32'h100, 0);                      // R6 disabled read
        run(1'b0, 2'd2, WBASE + 32'h40, 0);               // R5 window read
        run(1'b1, 2'd0, WBASE + 32'h13, 32'hFFFF_FFFF);   // R2 enable
        run(1'b0, 2'd2, 32'h100, 0);
        chk(last_beats == 8, "R1", "first enabled read misses", last_beats, 8);
        run(1'b0, 2'd2, 32'h104, 0);                      // R8 hit
        run(1'b0, 2'd0, 32'h101, 0);                      // R12 byte read returns word
        run(1'b0, 2'd2, 32'h40, 0);                       // fill line 2
        poke(32'h104, 32'h1234_5678);
        run(1'b0, 2'd2, 32'h104, 0);                      // R4 stale hit before invalidate
        run(1'b1, 2'd2, WBASE + 32'h108, 32'hDEAD_BEEF);  // R4 invalidate line 8
        run(1'b0, 2'd2, 32'h44, 0);
        chk(last_beats == 0, "R4", "other line still hits", last_beats, 0);
        run(1'b0, 2'd2, 32'h104, 0);
        chk(last_beats == 8, "R4", "invalidated line refetched", last_beats, 8);
        run(1'b1, 2'd1, 32'h106, 32'hBEEF_0000);          // R10 store hit
        run(1'b0, 2'd2, 32'h104, 0);
        run(1'b1, 2'd2, 32'h800, 32'hCAFE_F00D);          // R10 store miss
        run(1'b0, 2'd2, 32'h800, 0);
        chk(last_beats == 8, "R10", "store miss did not allocate", last_beats, 8);
        run(1'b1, 2'd1, WBASE + 32'h22, 0);               // R3 disable
        run(1'b0, 2'd2, 32'h40, 0);
        chk(last_beats == 1, "R3", "disabled read is single beat", last_beats, 1);
        run(1'b1, 2'd2, 32'h44, 32'h0BAD_0BAD);           // store while disabled
        run(1'b1, 2'd0, WBASE, 0);                        // re-enable
        run(1'b0, 2'd2, 32'h40, 0);
        chk(last_beats == 0, "R3", "contents kept across disable", last_beats, 0);
        for (int k = 0; k < NLINES; k++)
            run(1'b1, 2'd2, WBASE + 32'(k * 32 + (k % 8) * 4), 0);   // R11 flush
        for (int k = 0; k < NLINES; k++) begin
            run(1'b0, 2'd2, 32'(k * 32), 0);
            chk(last_beats == 8, "R11", "line empty after flush", last_beats, 8);
        end

        for (int i = 0; i < 600; i++) begin
            kind = $urandom_range(0, 99);
            a = ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 4095)) : 32'($urandom_range(0, 1023));
            if (kind < 45)      run(1'b0, 2'($urandom_range(0, 2)), a, 0);
            else if (kind < 85) run(1'b1, 2'($urandom_range(0, 2)), a, $urandom());
            else if (kind < 91) run(1'b1, 2'd2, WBASE + (32'($urandom_range(0, CB - 1)) & ~32'd3), $urandom());
            else if (kind < 94) run(1'b1, 2'd0, WBASE + 32'($urandom_range(0, CB - 1)), $urandom());
            else if (kind < 96) run(1'b1, 2'd1, WBASE + (32'($urandom_range(0, CB - 1)) & ~32'd1), $urandom());
            else                run(1'b0, 2'd2, WBASE + (32'($urandom_range(0, CB - 1)) & ~32'd3), 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule